// File: doc/BRIEF.md
# Video Sync Pulse Generator

This block rebuilds the timing of an incoming raster from its active-low horizontal and vertical sync inputs. It keeps a pixel counter and a line counter. Each counter is slaved to the falling edge of its sync input rather than running free. From the two counts it decodes the timing pulses that the rest of an encoder needs: blanking, horizontal sync, vertical sync, broad pulses and the colour-burst gate. The pulse positions come from a preset. An HD/SD flag picks the preset family, and a 4-bit standard code picks the format within that family.

The block also forms a digital composite sync from the decoded pulses. It turns that sync into a shaped analogue-style level whose edges follow a smooth raised-cosine-like ramp from a computed lookup table. That level is scaled by an 8-bit amplitude value. A field flag is captured at each vertical reference so that interlaced frames can tell their two fields apart. Progressive sources tie that flag to 0.

Two presets are built in. The HD preset (standard code 4) has 1650 pixels per line and 750 lines per frame. The SD preset (standard code 0) has 858 pixels per line and 525 lines per frame.

Top module: `sync_pulse_gen`

## Requirements
- R1: While the asynchronous active-low reset is held, every output reads 0.
- R2: Each sync input passes through two synchronizing flops. A high-to-low transition of `hsync_n` that is applied before clock edge k makes `pix_cnt` read 0 after edge k+3. After that, the count rises by 1 per clock and wraps to 0 after the preset's last pixel (1649 in HD, 858-1 = 857 in SD). A rising edge or a held level never resets the count.
- R3: A high-to-low transition of `vsync_n` sets `line_cnt` to 0 with the same latency as R2. `line_cnt` rises by 1 whenever a new line starts, which is a horizontal falling edge or a pixel wrap. Both events in the same cycle count as one step.
- R4: `blank` is 0 only inside the active window. In HD that window is pixels 260..1539 on lines 25..744. In SD it is pixels 130..849 on lines 20..262.
- R5: `hsync_pulse` is 1 for pixels below 40 (HD) or 64 (SD). `vsync_pulse` is 1 for lines below 5 (HD) or 3 (SD). `broad_pulse` is 1 on those vertical-sync lines for pixels below 1400 (HD) or 365 (SD).
- R6: `burst_gate` is 1 for pixels 60..139 (HD) or 76..109 (SD), except on vertical-sync lines, where it stays 0.
- R7: `csync` follows `broad_pulse` on vertical-sync lines and `hsync_pulse` on all other lines.
- R8: `field_out` takes the value that `field_in` holds when the vertical falling edge is taken. It appears with the same latency as `line_cnt` = 0 and holds until the next vertical edge.
- R9: `sd_mode`=0 with code 4, and `sd_mode`=1 with code 0, select the HD and SD presets. Any other code falls back to the preset of the family chosen by `sd_mode`.
- R10: A ramp phase p (0..16) counts up by one per clock while the registered `csync` is 1 and down by one per clock while it is 0, saturating at both ends. `sync_level` = (L(p) × A) >> 8, where L(p) = floor(255·(48p² − 2p³)/4096) and A is the amplitude registered at the last edge.
- R11: Amplitude values above 166 are treated as 166, so `sync_level` never exceeds 165.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| hsync_n | input | 1 | Horizontal sync, active low, falling edge is 0H |
| vsync_n | input | 1 | Vertical sync, active low, falling edge is line 0 |
| field_in | input | 1 | 0 first field, 1 second field; 0 for progressive |
| sd_mode | input | 1 | 0 selects the HD family, 1 the SD family |
| std_code | input | 4 | Standard within the family (4 = HD 1650×750, 0 = SD 858×525) |
| sync_amp | input | 8 | Sync amplitude, unsigned, clamped to 166 |
| pix_cnt | output | 12 | Registered pixel count |
| line_cnt | output | 11 | Registered line count |
| field_out | output | 1 | Captured field flag |
| blank | output | 1 | Blanking, 1 outside the active picture |
| hsync_pulse | output | 1 | Horizontal sync pulse |
| vsync_pulse | output | 1 | Vertical sync interval |
| broad_pulse | output | 1 | Broad pulse within vertical sync lines |
| burst_gate | output | 1 | Colour-burst window |
| csync | output | 1 | Digital composite sync |
| sync_level | output | 8 | Shaped, amplitude-scaled sync level |

## Verification
A sync input value applied before edge k is first seen by the counters after edge k+2 and by every decoded output after edge k+3. The bench therefore compares each output, at the falling clock edge, against its own raster position taken three pixels back, with a borrow across lines and frames. The field flag follows the same three-cycle delay. Its check switches to the previous frame's value while the delayed position still lies in the old frame. The shaped level has one more register in its path, the ramp phase, which follows the composite sync sampled one cycle earlier. The bench's ramp model therefore steps on the composite sync it sampled at the previous falling edge, and it scales by the amplitude driven before the latest edge.

// File: rtl/sync_pkg.sv
package sync_pkg;

   localparam int PIX_W  = 12;
   localparam int LINE_W = 11;
   localparam int AMP_W  = 8;
   localparam int LVL_W  = 8;

   localparam logic [3:0] HD_CODE = 4'd4;
   localparam logic [3:0] SD_CODE = 4'd0;

   typedef struct packed {
      logic [PIX_W-1:0]  h_total;
      logic [PIX_W-1:0]  hs_len;
      logic [PIX_W-1:0]  burst_s;
      logic [PIX_W-1:0]  burst_e;
      logic [PIX_W-1:0]  act_s;
      logic [PIX_W-1:0]  act_e;
      logic [PIX_W-1:0]  broad_s;
      logic [PIX_W-1:0]  broad_e;
      logic [LINE_W-1:0] v_total;
      logic [LINE_W-1:0] vs_lines;
      logic [LINE_W-1:0] vact_s;
      logic [LINE_W-1:0] vact_e;
   } raster_preset_t;

   localparam raster_preset_t HD_PRESET = '{
      h_total: 12'd1650, hs_len: 12'd40,
      burst_s: 12'd60,   burst_e: 12'd140,
      act_s:   12'd260,  act_e:   12'd1540,
      broad_s: 12'd0,    broad_e: 12'd1400,
      v_total: 11'd750,  vs_lines: 11'd5,
      vact_s:  11'd25,   vact_e:  11'd745 };

   localparam raster_preset_t SD_PRESET = '{
      h_total: 12'd858,  hs_len: 12'd64,
      burst_s: 12'd76,   burst_e: 12'd110,
      act_s:   12'd130,  act_e:   12'd850,
      broad_s: 12'd0,    broad_e: 12'd365,
      v_total: 11'd525,  vs_lines: 11'd3,
      vact_s:  11'd20,   vact_e:  11'd263 };

   function automatic raster_preset_t preset_for(input logic sd, input logic [3:0] code);
      raster_preset_t p;
      case ({sd, code})
         {1'b0, HD_CODE}: p = HD_PRESET;
         {1'b1, SD_CODE}: p = SD_PRESET;
         default:         p = sd ? SD_PRESET : HD_PRESET;
      endcase
      return p;
   endfunction

   // Cubic smoothstep, close to a raised cosine, full scale 255.
   function automatic int ramp_point(input int i, input int n);
      return (255 * (3 * i * i * n - 2 * i * i * i)) / (n * n * n);
   endfunction

endpackage

// File: rtl/sync_edge_det.sv
module sync_edge_det #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din_n,
   output logic fall
);
   logic [STAGES:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '1;
      else        chain <= {chain[STAGES-1:0], din_n};
   end

   assign fall = chain[STAGES] & ~chain[STAGES-1];
endmodule

// File: rtl/raster_counters.sv
module raster_counters
   import sync_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              h_fall,
   input  logic              v_fall,
   input  logic              field_in,
   input  logic [PIX_W-1:0]  h_total,
   input  logic [LINE_W-1:0] v_total,
   output logic [PIX_W-1:0]  pix,
   output logic [LINE_W-1:0] line,
   output logic              field_q
);
   logic line_start;
   logic line_last;

   assign line_start = h_fall || (pix == h_total - PIX_W'(1));
   assign line_last  = (line == v_total - LINE_W'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pix     <= '0;
         line    <= '0;
         field_q <= 1'b0;
      end else begin
         pix <= line_start ? '0 : pix + PIX_W'(1);
         if (v_fall) begin
            line    <= '0;
            field_q <= field_in;
         end else if (line_start) begin
            line <= line_last ? '0 : line + LINE_W'(1);
         end
      end
   end
endmodule

// File: rtl/pulse_decode.sv
module pulse_decode
   import sync_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  raster_preset_t    p,
   input  logic [PIX_W-1:0]  pix,
   input  logic [LINE_W-1:0] line,
   input  logic              field_q,
   output logic [PIX_W-1:0]  pix_o,
   output logic [LINE_W-1:0] line_o,
   output logic              field_o,
   output logic              blank_o,
   output logic              hs_o,
   output logic              vs_o,
   output logic              broad_o,
   output logic              burst_o,
   output logic              csync_o
);
   logic hs, vs, broad, burst, h_act, v_act;

   always_comb begin
      hs    = pix < p.hs_len;
      vs    = line < p.vs_lines;
      h_act = (pix >= p.act_s) && (pix < p.act_e);
      v_act = (line >= p.vact_s) && (line < p.vact_e);
      broad = vs && (pix >= p.broad_s) && (pix < p.broad_e);
      burst = !vs && (pix >= p.burst_s) && (pix < p.burst_e);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pix_o   <= '0;
         line_o  <= '0;
         field_o <= 1'b0;
         blank_o <= 1'b0;
         hs_o    <= 1'b0;
         vs_o    <= 1'b0;
         broad_o <= 1'b0;
         burst_o <= 1'b0;
         csync_o <= 1'b0;
      end else begin
         pix_o   <= pix;
         line_o  <= line;
         field_o <= field_q;
         blank_o <= !(h_act && v_act);
         hs_o    <= hs;
         vs_o    <= vs;
         broad_o <= broad;
         burst_o <= burst;
         csync_o <= vs ? broad : hs;
      end
   end
endmodule

// File: rtl/sync_shaper.sv
module sync_shaper
   import sync_pkg::*;
#(
   parameter int RAMP_LEN = 16,
   parameter int AMP_MAX  = 166
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             csync,
   input  logic [AMP_W-1:0] amp,
   output logic [LVL_W-1:0] level
);
   localparam int PH_W = $clog2(RAMP_LEN + 1);

   logic [PH_W-1:0]        ph;
   logic [AMP_W-1:0]       amp_q;
   logic [7:0]             lut [RAMP_LEN+1];
   logic [AMP_W+7:0]       prod;

   for (genvar i = 0; i <= RAMP_LEN; i++) begin : g_lut
      assign lut[i] = 8'(ramp_point(i, RAMP_LEN));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ph    <= '0;
         amp_q <= '0;
      end else begin
         amp_q <= (amp > AMP_W'(AMP_MAX)) ? AMP_W'(AMP_MAX) : amp;
         if (csync) begin
            if (ph != PH_W'(RAMP_LEN)) ph <= ph + PH_W'(1);
         end else begin
            if (ph != '0) ph <= ph - PH_W'(1);
         end
      end
   end

   assign prod  = lut[ph] * amp_q;
   assign level = LVL_W'(prod >> 8);
endmodule

// File: rtl/sync_pulse_gen.sv
module sync_pulse_gen
   import sync_pkg::*;
#(
   parameter int SYNC_STAGES = 2,
   parameter int RAMP_LEN    = 16,
   parameter int AMP_MAX     = 166
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              hsync_n,
   input  logic              vsync_n,
   input  logic              field_in,
   input  logic              sd_mode,
   input  logic [3:0]        std_code,
   input  logic [AMP_W-1:0]  sync_amp,
   output logic [PIX_W-1:0]  pix_cnt,
   output logic [LINE_W-1:0] line_cnt,
   output logic              field_out,
   output logic              blank,
   output logic              hsync_pulse,
   output logic              vsync_pulse,
   output logic              broad_pulse,
   output logic              burst_gate,
   output logic              csync,
   output logic [LVL_W-1:0]  sync_level
);
   if (SYNC_STAGES < 2) begin : g_bad_stages
      $error("SYNC_STAGES must be at least 2");
   end
   if (RAMP_LEN < 2 || RAMP_LEN > 64) begin : g_bad_ramp
      $error("RAMP_LEN must lie in 2..64");
   end
   if (AMP_MAX < 1 || AMP_MAX > 255) begin : g_bad_amp
      $error("AMP_MAX must fit the amplitude field");
   end

   raster_preset_t    preset;
   logic              h_fall, v_fall, field_q;
   logic [PIX_W-1:0]  pix;
   logic [LINE_W-1:0] line;

   assign preset = preset_for(sd_mode, std_code);

   sync_edge_det #(.STAGES(SYNC_STAGES)) u_hdet (
      .clk(clk), .rst_n(rst_n), .din_n(hsync_n), .fall(h_fall));

   sync_edge_det #(.STAGES(SYNC_STAGES)) u_vdet (
      .clk(clk), .rst_n(rst_n), .din_n(vsync_n), .fall(v_fall));

   raster_counters u_cnt (
      .clk(clk), .rst_n(rst_n), .h_fall(h_fall), .v_fall(v_fall),
      .field_in(field_in), .h_total(preset.h_total), .v_total(preset.v_total),
      .pix(pix), .line(line), .field_q(field_q));

   pulse_decode u_dec (
      .clk(clk), .rst_n(rst_n), .p(preset), .pix(pix), .line(line),
      .field_q(field_q), .pix_o(pix_cnt), .line_o(line_cnt),
      .field_o(field_out), .blank_o(blank), .hs_o(hsync_pulse),
      .vs_o(vsync_pulse), .broad_o(broad_pulse), .burst_o(burst_gate),
      .csync_o(csync));

   sync_shaper #(.RAMP_LEN(RAMP_LEN), .AMP_MAX(AMP_MAX)) u_shape (
      .clk(clk), .rst_n(rst_n), .csync(csync), .amp(sync_amp),
      .level(sync_level));
endmodule

// File: rtl/sync_pulse_gen_chk.sv
module sync_pulse_gen_chk
   import sync_pkg::*;
#(
   parameter int AMP_MAX = 166
) (
   input logic              clk,
   input logic              rst_n,
   input logic [PIX_W-1:0]  pix_cnt,
   input logic [LINE_W-1:0] line_cnt,
   input logic              hsync_pulse,
   input logic              vsync_pulse,
   input logic              broad_pulse,
   input logic              burst_gate,
   input logic              csync,
   input logic [LVL_W-1:0]  sync_level
);
   localparam int LVL_CAP = (255 * AMP_MAX) / 256;

   assert_pix_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (pix_cnt != '0) |-> (pix_cnt == $past(pix_cnt) + PIX_W'(1)));

   assert_line_move_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (line_cnt != $past(line_cnt)) |-> (pix_cnt == '0 || line_cnt == '0));

   assert_broad_in_vs_R5: assert property (@(posedge clk) disable iff (!rst_n)
      broad_pulse |-> vsync_pulse);

   assert_burst_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
      burst_gate |-> !vsync_pulse);

   assert_csync_h_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (csync && !vsync_pulse) |-> hsync_pulse);

   assert_level_cap_R11: assert property (@(posedge clk) disable iff (!rst_n)
      sync_level <= LVL_W'(LVL_CAP));
endmodule

bind sync_pulse_gen sync_pulse_gen_chk #(.AMP_MAX(AMP_MAX)) u_chk (
   .clk(clk), .rst_n(rst_n), .pix_cnt(pix_cnt), .line_cnt(line_cnt),
   .hsync_pulse(hsync_pulse), .vsync_pulse(vsync_pulse),
   .broad_pulse(broad_pulse), .burst_gate(burst_gate), .csync(csync),
   .sync_level(sync_level));

// File: tb/tb_sync_pulse_gen.sv
module tb_sync_pulse_gen;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        hsync_n = 1'b1, vsync_n = 1'b1, field_in = 1'b0, sd_mode = 1'b0;
   logic [3:0]  std_code = 4'd4;
   logic [7:0]  sync_amp = 8'd128;
   logic [11:0] pix_cnt;
   logic [10:0] line_cnt;
   logic        field_out, blank, hsync_pulse, vsync_pulse, broad_pulse, burst_gate, csync;
   logic [7:0]  sync_level;

   int n_chk = 0, n_err = 0;
   bit done = 0;

   // bench-side preset numbers and raster state
   int H, HS, BS, BE, AS, AE, BRE, VS, VAS, VAE;
   int sp, sl, fr_lines;
   bit fld_cur, fld_prev;
   int ph_m;
   bit cs_prev;

   always #4 clk = ~clk;

   sync_pulse_gen dut (
      .clk(clk), .rst_n(rst_n), .hsync_n(hsync_n), .vsync_n(vsync_n),
      .field_in(field_in), .sd_mode(sd_mode), .std_code(std_code),
      .sync_amp(sync_amp), .pix_cnt(pix_cnt), .line_cnt(line_cnt),
      .field_out(field_out), .blank(blank), .hsync_pulse(hsync_pulse),
      .vsync_pulse(vsync_pulse), .broad_pulse(broad_pulse),
      .burst_gate(burst_gate), .csync(csync), .sync_level(sync_level));

   task automatic chk(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_err++;
         $display("FAIL %s actual=%0d expected=%0d (src %0d,%0d)", req, act, exp, sl, sp);
      end
   endtask

   function automatic int ramp_lut(input int i);
      return (255 * (48 * i * i - 2 * i * i * i)) / 4096;
   endfunction

   function automatic int clamp_amp(input int a);
      return (a > 166) ? 166 : a;
   endfunction

   task automatic load_preset(input bit sd);
      if (!sd) begin
         H = 1650; HS = 40; BS = 60; BE = 140; AS = 260; AE = 1540;
         BRE = 1400; VS = 5; VAS = 25; VAE = 745;
      end else begin
         H = 858; HS = 64; BS = 76; BE = 110; AS = 130; AE = 850;
         BRE = 365; VS = 3; VAS = 20; VAE = 263;
      end
   endtask

   task automatic apply_src();
      hsync_n = !(sp < 8);
      vsync_n = !(sl < 3);
   endtask

   // sample after an edge: compare against source position three pixels back
   task automatic check_cycle(input int cyc);
      int dp, dl;
      bit fexp, vs_e, hs_e;
      // shaped level model (R10, R11)
      if (cs_prev) begin if (ph_m < 16) ph_m++; end
      else begin if (ph_m > 0) ph_m--; end
      chk((sync_amp > 8'd166) ? "R11 level clamp" : "R10 level ramp", int'(sync_level),
          (ramp_lut(ph_m) * clamp_amp(int'(sync_amp))) >> 8);
      cs_prev = csync;
      if (cyc < 4) return;
      dp = sp - 3; dl = sl;
      if (dp < 0) begin
         dp += H; dl--;
         if (dl < 0) dl = fr_lines - 1;
      end
      fexp = (sl == 0 && sp < 3) ? fld_prev : fld_cur;
      chk("R2 pixel count", int'(pix_cnt), dp);
      chk("R3 line count", int'(line_cnt), dl);
      chk("R8 field flag", int'(field_out), int'(fexp));
      vs_e = dl < VS;
      hs_e = dp < HS;
      chk("R4 R9 blanking", int'(blank), int'(!(dp >= AS && dp < AE && dl >= VAS && dl < VAE)));
      chk("R5 R9 hsync", int'(hsync_pulse), int'(hs_e));
      chk("R5 vsync", int'(vsync_pulse), int'(vs_e));
      chk("R5 broad", int'(broad_pulse), int'(vs_e && dp < BRE));
      chk("R6 burst gate", int'(burst_gate), int'(!vs_e && dp >= BS && dp < BE));
      chk("R7 composite sync", int'(csync), int'(vs_e ? (dp < BRE) : hs_e));
   endtask

   task automatic check_reset();
      chk("R1 reset pix", int'(pix_cnt), 0);
      chk("R1 reset line", int'(line_cnt), 0);
      chk("R1 reset pulses", int'({field_out, blank, hsync_pulse, vsync_pulse,
                                   broad_pulse, burst_gate, csync}), 0);
      chk("R1 reset level", int'(sync_level), 0);
   endtask

   task automatic run_mode(input bit sd, input int lines, input int frames);
      int cyc;
      rst_n = 1'b0;
      sd_mode = sd;
      load_preset(sd);
      fr_lines = lines;
      sp = 0; sl = 0; ph_m = 0; cs_prev = 0;
      fld_cur = 1'b0; fld_prev = 1'b0; field_in = 1'b0;
      std_code = sd ? 4'd0 : 4'd4;
      sync_amp = 8'd255;
      apply_src();
      repeat (3) @(negedge clk);
      check_reset();
      rst_n = 1'b1;
      cyc = 0;
      for (int n = 0; n < frames * lines * H; n++) begin
         @(negedge clk);
         cyc++;
         check_cycle(cyc);
         sp++;
         if (sp == H) begin
            sp = 0; sl++;
            if (sl == fr_lines) begin
               sl = 0;
               fld_prev = fld_cur;
               fld_cur = ~fld_cur;
               field_in = fld_cur;
               // unsupported codes must fall back to the family preset (R9)
               std_code = 4'($urandom_range(0, 15));
            end
            // random amplitude, including values above the clamp (R11)
            if (n > lines * H) sync_amp = 8'($urandom_range(0, 255));
            else if (sl == 2) sync_amp = 8'd166;
         end
         apply_src();
      end
   endtask

   initial begin
      void'($urandom(32'd1234));
      run_mode(1'b0, 30, 2);
      run_mode(1'b1, 26, 2);
      done = 1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

   initial begin
      repeat (190000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_err++;
         $display("FAIL watchdog actual=timeout expected=completion");
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   end
endmodule